// File: doc/BRIEF.md
# Early-Terminating Shift-Add Multiplier

This block multiplies two unsigned operands one step at a time by conditional addition. A pulse on `start` loads the two operands and clears the accumulator. On each working cycle, the block looks at the lowest bit of the remaining multiplier. If that bit is one, the block adds the current multiplicand to the accumulator. The multiplicand then moves one place left and the multiplier one place right.

The run ends on the first cycle in which the remaining multiplier is zero. The latency therefore follows the position of the multiplier's highest set bit, not the operand width. For example, a multiplier of 3 finishes after two working cycles.

The block holds the result on `product` until the next accepted start. It signals completion with a one-cycle `done` pulse. `busy` covers the whole run, and a new start is ignored while `busy` is high. The accumulator may be built as two halves, with the carry out of the low half rippling into the high half. This keeps each adder at operand width.

Top module: `shiftAddMul`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` seen while `busy` is low captures both operands and clears the accumulator; `busy` is high on the following cycle.
- R3: When `done` is high, `product` equals the unsigned product of the captured multiplicand and multiplier, 2*WIDTH bits wide.
- R4: Let the start clock edge be cycle 0, and let L be the bit length of the multiplier (the index of its highest set bit plus one, or 0 for zero). `done` is then high in cycle L+1, which ends the run early for short multipliers.
- R5: A multiplier of zero gives `done` in the first cycle after start, with `product` equal to zero.
- R6: `start` and the operand inputs are ignored while `busy` is high; the running product, and the latency, are unchanged by them.
- R7: `done` is high for exactly one cycle, and `busy` is low in the cycle after `done`.
- R8: While the block is idle and `start` is low, `product` holds its last value.
- R9: A carry out of the low half of the accumulator reaches the high half, so all-ones operands give (2^WIDTH-1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication using the operands present this cycle |
| multiplicandIn | input | WIDTH | Unsigned multiplicand |
| multiplierIn | input | WIDTH | Unsigned multiplier; its bit length sets the latency |
| busy | output | 1 | High from the cycle after an accepted start up to and including the done cycle |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2*WIDTH | Accumulated product, held until the next accepted start |

## Verification
The bench builds the block with the default WIDTH of 8 and the split accumulator. With 8-bit operands, every multiplier bit length from 0 to 8 is reachable, so the exact latency rule can be checked at each length. All-ones operands force carries out of the low half into the high half. The short run length also leaves room to inject a second start in the middle of a run and to watch the hold behaviour afterwards.

// File: rtl/mulPkg.sv
package mulPkg;
  typedef enum logic {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mulState_t;

  typedef struct packed {
    logic load;
    logic step;
  } mulStrobes_t;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        mplierZero,
  output mulStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  mulState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= MUL_IDLE;
    end else begin
      case (state)
        MUL_IDLE: if (start) state <= MUL_RUN;
        MUL_RUN:  if (mplierZero) state <= MUL_IDLE;
        default:  state <= MUL_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load = (state == MUL_IDLE) && start;
    strobes.step = (state == MUL_RUN) && !mplierZero;
    busy         = (state == MUL_RUN);
    done         = (state == MUL_RUN) && mplierZero;
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: busy drops right after done
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R2: an accepted start raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit SPLIT_ACC = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobes_t        strobes,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic               mplierZero,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;
  localparam int HW = PW / 2;

  logic [PW-1:0]    mcand;
  logic [WIDTH-1:0] mplier;
  logic [PW-1:0]    acc;
  logic [PW-1:0]    accSum;

  generate
    if (SPLIT_ACC) begin : g_split
      logic [HW:0]   lowSum;
      logic [HW-1:0] highSum;
      always_comb begin
        lowSum  = {1'b0, acc[HW-1:0]} + {1'b0, mcand[HW-1:0]};
        highSum = acc[PW-1:HW] + mcand[PW-1:HW] + {{(HW-1){1'b0}}, lowSum[HW]};
        accSum  = {highSum, lowSum[HW-1:0]};
      end
    end else begin : g_flat
      always_comb accSum = acc + mcand;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
    end else if (strobes.load) begin
      acc    <= '0;
      mcand  <= {{WIDTH{1'b0}}, multiplicandIn};
      mplier <= multiplierIn;
    end else if (strobes.step) begin
      if (mplier[0]) acc <= accSum;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

  assign mplierZero = (mplier == '0);
  assign product    = acc;

  // R3: partial products never wrap the accumulator
  p_acc_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> acc >= $past(acc));
  // R4: each step consumes one multiplier bit
  p_mplier_shrinks_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> mplier < $past(mplier));
endmodule

// File: rtl/shiftAddMul.sv
module shiftAddMul
  import mulPkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit SPLIT_ACC = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  mulStrobes_t strobes;
  logic        mplierZero;

  mulCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .mplierZero (mplierZero),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done)
  );

  mulDatapath #(.WIDTH(WIDTH), .SPLIT_ACC(SPLIT_ACC)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .multiplicandIn (multiplicandIn),
    .multiplierIn   (multiplierIn),
    .mplierZero     (mplierZero),
    .product        (product)
  );

  // R5: zero multiplier finishes at once with a zero product
  p_zero_fast_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && multiplierIn == '0) |=> (done && product == '0));
  // R8: idle result holds
  p_product_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));
  // R6: a start during a run does not disturb it
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);
endmodule

// File: tb/tb_shiftAddMul.sv
module tb_shiftAddMul;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   aIn = '0;
  logic [W-1:0]   bIn = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  shiftAddMul #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicandIn(aIn), .multiplierIn(bIn),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bitLen(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  // Runs one multiplication; optionally injects a start at cycle injectAt.
  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag, input int injectAt);
    int cyc = 0;
    longint expP = longint'(a) * longint'(b);
    @(negedge clk);
    aIn = a; bIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
    while (!done && cyc < 40) begin
      if (cyc == injectAt) begin
        aIn = ~a; bIn = 8'h01; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(done == 1'b1, {tag, " R4 done seen"}, done, 1);
    check(cyc == bitLen(b) + 1, {tag, " R4 latency"}, cyc, bitLen(b) + 1);
    check(product == expP[2*W-1:0], {tag, " R3 product"}, product, expP);
    @(negedge clk);
    check(!done && !busy, {tag, " R7 done pulse ends"}, {done, busy}, 0);
  endtask

  task automatic testReset();
    check(!busy && !done && product == '0, "R1 reset state", product, 0);
  endtask

  task automatic testZero();
    runMul(8'hA7, 8'h00, "R5 zero multiplier", -1);
    check(product == '0, "R5 zero product", product, 0);
  endtask

  task automatic testPatterns();
    runMul(8'd117, 8'd3,   "small multiplier", -1);
    runMul(8'd81,  8'd109, "mixed bits", -1);
    runMul(8'd5,   8'h80,  "top bit only", -1);
    runMul(8'd200, 8'h01,  "one", -1);
    for (int k = 0; k < W; k++) runMul(8'd37 + 8'(k), 8'(1 << k) | 8'(k), "length sweep", -1);
  endtask

  task automatic testCarry();
    runMul(8'hFF, 8'hFF, "R9 all ones carry", -1);
    check(product == 16'hFE01, "R9 high half", product, 16'hFE01);
  endtask

  task automatic testIgnore();
    runMul(8'd3, 8'hFF, "R6 start ignored", 3);
  endtask

  task automatic testHold();
    logic [2*W-1:0] held;
    runMul(8'd99, 8'd45, "R8 setup", -1);
    held = product;
    for (int i = 0; i < 5; i++) begin
      aIn = 8'(i * 31); bIn = 8'(i * 7 + 1);
      @(negedge clk);
      check(product == held && !busy, "R8 hold while idle", product, held);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZero();
    testPatterns();
    testCarry();
    testIgnore();
    testHold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule